// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a simple synchronous request port to an external 128K x 8 asynchronous static RAM. The memory has a pair of chip selects of opposite polarity (one active low, one active high), an active-low output enable, an active-low write enable, a 17-bit address and an 8-bit data bus. The controller takes one read or write at a time. It steps the memory strobes through a fixed order and holds each phase for a whole number of clock cycles. Those counts are derived from nanosecond limits and the clock period, so one parameter set covers either the 55 ns or the 70 ns speed grade.

The bidirectional data bus is split into three signals: a drive value, a drive enable and a sampled input. The tristate buffer belongs in the pad ring. A read runs as follows: select the chip, wait out the setup phase, hold output enable low for the access phase, capture the data on the last access cycle, then pulse `done` together with the data. A write is controlled by write enable and runs in this order: select with data already driven, setup, write pulse, then recovery with address and data still held. Between accesses the memory is deselected and both strobes are high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and after reset, `ready`=1, `done`=0, `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A write request (`req_write`=1) stores `req_wdata` at `req_addr`, and a later read of that address returns it.
- R3: A read request (`req_write`=0) returns the byte held at `req_addr` on `rd_data`, valid in the cycle where `done` is 1.
- R4: `mem_we_n` goes low only while `mem_cs1_n`=0, `mem_cs2`=1 and `mem_dq_oe`=1. It stays low for exactly ceil(max(write pulse, data overlap)/clock) cycles, which is 5 with the defaults (40 ns, 20 ns, 8 ns clock).
- R5: `mem_addr` does not change in any cycle where the chip was also selected in the previous cycle.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n`=0, and it is 0 in the cycle before `mem_oe_n` falls.
- R7: A read holds `mem_oe_n` low, with `mem_we_n` high, for exactly ceil(access time/clock) cycles, which is 7 with the defaults.
- R8: After the chip is selected, it stays selected with both strobes high for exactly `SETUP_CYC` cycles (default 1) before either strobe falls.
- R9: `ready` is 1 only while the memory is idle. A request presented while `ready`=0 is ignored and changes no memory contents.
- R10: `mem_oe_n` and `mem_we_n` are never low together.
- R11: `done` is one cycle wide and pulses exactly once per accepted request, reads and writes alike.
- R12: Between two accesses the chip stays deselected for at least recovery+1 cycles. Recovery is at least 1 cycle and is lengthened until setup+phase+recovery covers the cycle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address lines |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data value to drive onto the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Data sampled from the bus |

## Verification
The assertions check on every cycle that the strobes never overlap, that the data driver is off around output enable, that write enable only falls while the chip is selected and the bus is driven, that the address holds while the chip is selected, and that `done` lasts a single cycle. Some properties only the bench scenarios can show. These are the exact lengths of the setup, write-pulse, access and deselect phases, and that data read back matches earlier writes. They also include the rejection of requests made while busy. A memory model in the bench returns invalid data when output enable has been low for too short a time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_WPULSE,
    PH_ACCESS,
    PH_RECOV
  } phase_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  // a phase loaded with len lasts len cycles; last marks its final cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_on,
  input  logic              drive_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else if (drive_on) begin
      dq_o  <= wdata;
      dq_oe <= 1'b1;
    end else if (drive_off) begin
      dq_oe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= dq_i;
    end
  end

  // R6
  drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(drive_on && capture));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_ACCESS_NS   = 55,
  parameter int T_WPULSE_NS   = 40,
  parameter int T_DSETUP_NS   = 20,
  parameter int SETUP_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int WP_CYC    = max2(1, ceil_div(max2(T_WPULSE_NS, T_DSETUP_NS) * 1000, CLK_PERIOD_PS));
  localparam int ACC_CYC   = max2(1, ceil_div(T_ACCESS_NS * 1000, CLK_PERIOD_PS));
  localparam int TRC_CYC   = ceil_div(T_CYCLE_NS * 1000, CLK_PERIOD_PS);
  localparam int SHORT_CYC = (WP_CYC < ACC_CYC) ? WP_CYC : ACC_CYC;
  localparam int RECOV_CYC = max2(1, TRC_CYC - SETUP_CYC - SHORT_CYC);
  localparam int LONGEST   = max2(max2(WP_CYC, ACC_CYC), max2(RECOV_CYC, SETUP_CYC));
  localparam int CNT_W     = $clog2(LONGEST + 1);

  phase_t           phase;
  logic             is_wr;
  logic             last;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             accept;

  assign accept = (phase == PH_IDLE) && req_valid;

  // length of the phase entered on the coming edge
  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(SETUP_CYC);
    unique case (phase)
      PH_IDLE: begin
        tmr_load = req_valid;
        tmr_len  = CNT_W'(SETUP_CYC);
      end
      PH_SETUP: begin
        tmr_load = last;
        tmr_len  = is_wr ? CNT_W'(WP_CYC) : CNT_W'(ACC_CYC);
      end
      PH_WPULSE, PH_ACCESS: begin
        tmr_load = last;
        tmr_len  = CNT_W'(RECOV_CYC);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(SETUP_CYC);
      end
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .last (last)
  );

  sram_io_path #(.DATA_W(DATA_W)) u_io (
    .clk       (clk),
    .rst       (rst),
    .drive_on  (accept && req_write),
    .drive_off ((phase == PH_RECOV) && last),
    .wdata     (req_wdata),
    .capture   ((phase == PH_ACCESS) && last),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .dq_oe     (mem_dq_oe),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      is_wr     <= 1'b0;
      ready     <= 1'b1;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase     <= PH_SETUP;
            ready     <= 1'b0;
            is_wr     <= req_write;
            mem_addr  <= req_addr;
            mem_cs1_n <= 1'b0;
            mem_cs2   <= 1'b1;
          end
        end
        PH_SETUP: begin
          if (last) begin
            if (is_wr) begin
              phase    <= PH_WPULSE;
              mem_we_n <= 1'b0;
            end else begin
              phase    <= PH_ACCESS;
              mem_oe_n <= 1'b0;
            end
          end
        end
        PH_WPULSE, PH_ACCESS: begin
          if (last) begin
            phase     <= PH_RECOV;
            done      <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
          end
        end
        PH_RECOV: begin
          if (last) begin
            phase <= PH_IDLE;
            ready <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_oe_n || mem_we_n);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R4
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dq_oe));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n));

endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

  localparam int SETUP_EXP = 1;
  localparam int WP_EXP    = 5;
  localparam int ACC_EXP   = 7;
  localparam int RECOV_EXP = 1;
  localparam int VALID_AFTER = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #4 clk = ~clk;

  sram_bus_ctrl u_sram_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_issued = 0;
  int n_done = 0;
  bit finished = 0;

  logic [7:0] model_mem [int];
  logic [7:0] ref_mem [int];
  bit         q_wr [$];
  logic [7:0] q_exp [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // driver: one request, expected item pushed to the scoreboard
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    q_wr.push_back(wr);
    q_exp.push_back(wr ? d : ref_get(int'(a)));
    if (wr) ref_mem[int'(a)] = d;
    n_issued++;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: busy right after acceptance
    check(ready == 1'b0, "R9 ready after accept", int'(ready), 0);
  endtask

  // memory model and monitor
  int  we_run = 0, oe_run = 0, desel_run = 100, setup_cnt = 0;
  bit  strobe_seen = 0, prev_sel = 0;

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit sel = !mem_cs1_n && mem_cs2;
      if (!mem_oe_n && mem_dq_oe)
        check(0, "R6 contention", 1, 0);
      if (!mem_oe_n && !mem_we_n)
        check(0, "R10 strobe overlap", 0, 1);
      if (sel) begin
        if (!prev_sel) begin
          // R12 deselected gap
          check(desel_run >= RECOV_EXP + 1, "R12 deselect gap", desel_run, RECOV_EXP + 1);
          setup_cnt = 0; strobe_seen = 0;
        end
        if (!mem_we_n || !mem_oe_n) begin
          if (!strobe_seen)
            check(setup_cnt == SETUP_EXP, "R8 setup length", setup_cnt, SETUP_EXP);
          strobe_seen = 1;
        end else if (!strobe_seen) begin
          setup_cnt++;
        end
        desel_run = 0;
      end else begin
        desel_run++;
      end
      prev_sel = sel;
      // write pulse length R4
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin
        check(we_run == WP_EXP, "R4 write pulse", we_run, WP_EXP);
        we_run = 0;
      end
      // read window R7
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        check(oe_run == ACC_EXP, "R7 output enable window", oe_run, ACC_EXP);
        oe_run = 0;
      end
      if (sel && !mem_we_n && mem_dq_oe)
        model_mem[int'(mem_addr)] = mem_dq_o;
      if (sel && !mem_oe_n && mem_we_n && oe_run >= VALID_AFTER)
        mem_dq_i <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
      else
        mem_dq_i <= 8'hEE;
      // scoreboard
      if (done) begin
        n_done++;
        if (q_wr.size() == 0) begin
          check(0, "R11 unexpected done", 1, 0);
        end else begin
          automatic bit wr = q_wr.pop_front();
          automatic logic [7:0] e = q_exp.pop_front();
          if (!wr) check(rd_data == e, "R3 read data", int'(rd_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready && !done && mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset state", {ready, done, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe},
          7'b1010110);
    rst = 1'b0;
    @(negedge clk);
    check(ready && mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 idle after reset", int'(ready), 1);
    // R2/R3 basic patterns
    issue(1, 17'h00000, 8'h5A);
    issue(1, 17'h1FFFF, 8'hA5);
    issue(1, 17'h0AAAA, 8'hFF);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    issue(0, 17'h01234, 8'h00);
    // R9: request while busy is ignored
    issue(1, 17'h00100, 8'h11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00100; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    issue(0, 17'h00100, 8'h00);
    // R2 overwrite then read back, alternating
    for (int i = 0; i < 8; i++) begin
      issue(1, 17'(i * 4099), 8'(i * 37 + 3));
      issue(0, 17'(i * 4099), 8'h00);
    end
    issue(1, 17'h0AAAA, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    while (!ready || q_wr.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R11 one done per request
    check(n_done == n_issued, "R11 done count", n_done, n_issued);
    check(q_wr.size() == 0, "R11 scoreboard drained", q_wr.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule